// File: doc/BRIEF.md
# Time-of-Day Update Engine with Alarm

This block holds a calendar clock (seconds, minutes, hours, day of week, day of month, month and a two-digit year) and moves it forward by one second whenever a one-second tick arrives while the divider-control field selects normal running. Each accepted tick starts an update window. The time advances at once inside the block, and an update-in-progress flag is raised for the length of the window. When the window closes, the host-visible time registers are refreshed from the internal counters, the alarm is compared, and the sticky interrupt flags are set.

The internal counters are always binary. The visible registers are presented either in BCD or in binary, and either in 12-hour or in 24-hour form, as two format inputs select. A load strobe writes a new time, given in the currently selected format. A hold input (SET) freezes the visible registers so the host can rewrite them at leisure. While SET is high the internal time still counts and the alarm still watches it. When SET falls, the internal time is reloaded from the visible registers.

Top module: `tod_engine`

## Requirements
- R1: After reset the visible registers read seconds 00, minutes 00, hours 00, day of week 01, day of month 01, month 01 and year 00, and `uip`, `irqFlag`, `alarmFlag` and `doneFlag` are all 0.
- R2: A `secTick` pulse is accepted only when `divCtl` equals 3'b010. With any other `divCtl` value the tick is ignored and the time does not move.
- R3: In the cycle after an accepted tick, `uip` is 1 (unless SET is high). It stays 1 for exactly `UPD_CYCLES` cycles and falls in the same cycle the visible registers change. A tick that arrives while an update window is open is ignored.
- R4: At the end of an update with SET low, every visible register shows the advanced time. The encoding is BCD (tens in bits 7:4, units in bits 3:0) when `binMode` is 0, and plain binary when `binMode` is 1.
- R5: With `hr24` = 1 the hour register holds 0 to 23. With `hr24` = 0 it holds the 24-hour value mod 12 in bits 6:0, and bit 7 is set for hours 12 through 23.
- R6: The calendar follows the true month lengths. February has 29 days when the binary year is divisible by 4. Year 99 wraps to 00, month 12 wraps to 1, and day of week counts 1 to 7, with 7 wrapping to 1 at midnight.
- R7: While `setHold` is 1 the visible registers are not updated by the end of an update and `uip` stays 0, but the internal time still advances and is still compared against the alarm.
- R8: `loadStb` writes the load values into the visible registers on the next edge, in both SET states. With SET low it also loads the internal time. When SET falls, the internal time is loaded from the visible registers, decoded in the current format.
- R9: At the end of an update with `alarmEn` = 1, `alarmFlag` and `irqFlag` are set if the seconds, minutes and hours alarm fields all match. A field matches when it equals the visible-format value of the current time, or when its bits 7:6 are both 1.
- R10: At the end of every update with `doneEn` = 1, `doneFlag` and `irqFlag` are set.
- R11: The flags are sticky until `flagClr`. If a flag is set in the same cycle as `flagClr`, the set wins.
- R12: A `secTick` that arrives in the same cycle as `loadStb` is ignored. The loaded time stands and no update window opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-second tick pulse |
| divCtl | input | 3 | Divider control; 3'b010 means running |
| binMode | input | 1 | 1 = binary data, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| setHold | input | 1 | SET: freeze the visible registers |
| alarmEn | input | 1 | Alarm flag enable |
| doneEn | input | 1 | Update-ended flag enable |
| flagClr | input | 1 | Clear all flags |
| loadStb | input | 1 | Load strobe for the time values |
| loadSec | input | 8 | Seconds to load, in the current format |
| loadMin | input | 8 | Minutes to load |
| loadHour | input | 8 | Hours to load |
| loadDow | input | 8 | Day of week to load |
| loadDom | input | 8 | Day of month to load |
| loadMon | input | 8 | Month to load |
| loadYear | input | 8 | Year to load |
| alarmSec | input | 8 | Seconds alarm field |
| alarmMin | input | 8 | Minutes alarm field |
| alarmHour | input | 8 | Hours alarm field |
| uip | output | 1 | Update in progress |
| visSec | output | 8 | Visible seconds |
| visMin | output | 8 | Visible minutes |
| visHour | output | 8 | Visible hours |
| visDow | output | 8 | Visible day of week |
| visDom | output | 8 | Visible day of month |
| visMon | output | 8 | Visible month |
| visYear | output | 8 | Visible year |
| irqFlag | output | 1 | Any flag set |
| alarmFlag | output | 1 | Alarm matched |
| doneFlag | output | 1 | Update ended |

## Verification
The bench builds the block with `UPD_CYCLES` = 4 rather than the default 990. A full update then takes only a few cycles, which makes it cheap to sweep every hour under all four format combinations and to step across the last day of every month in leap, ordinary and wrapping years. With the window that short, the set-wins-over-clear edge and the tick-during-window case can also be aimed at individual cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DW = 8;
  localparam int ALARM_FIELDS = 3;
  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef logic [DW-1:0] byte_t;

  typedef struct packed {
    byte_t year;
    byte_t mon;
    byte_t dom;
    byte_t dow;
    byte_t hour;
    byte_t min;
    byte_t sec;
  } tod_t;

  typedef struct packed {
    logic advance;
    logic finish;
  } strobe_t;

  function automatic byte_t toBcd(byte_t v);
    return byte_t'(((v / 8'd10) << 4) | (v % 8'd10));
  endfunction

  function automatic byte_t fromBcd(byte_t x);
    return byte_t'(byte_t'(x[7:4]) * 8'd10 + byte_t'(x[3:0]));
  endfunction

  function automatic byte_t encVal(byte_t v, logic bin);
    return bin ? v : toBcd(v);
  endfunction

  function automatic byte_t decVal(byte_t x, logic bin);
    return bin ? x : fromBcd(x);
  endfunction

  function automatic byte_t monthDays(byte_t mon, byte_t year);
    case (mon)
      8'd2:                       return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
      default:                    return 8'd31;
    endcase
  endfunction

  function automatic tod_t encTod(tod_t t, logic bin, logic h24);
    tod_t r;
    r.sec  = encVal(t.sec, bin);
    r.min  = encVal(t.min, bin);
    r.dow  = encVal(t.dow, bin);
    r.dom  = encVal(t.dom, bin);
    r.mon  = encVal(t.mon, bin);
    r.year = encVal(t.year, bin);
    if (h24) r.hour = encVal(t.hour, bin);
    else     r.hour = encVal(t.hour % 8'd12, bin) | ((t.hour >= 8'd12) ? 8'h80 : 8'h00);
    return r;
  endfunction

  function automatic tod_t decTod(tod_t x, logic bin, logic h24);
    tod_t r;
    r.sec  = decVal(x.sec, bin);
    r.min  = decVal(x.min, bin);
    r.dow  = decVal(x.dow, bin);
    r.dom  = decVal(x.dom, bin);
    r.mon  = decVal(x.mon, bin);
    r.year = decVal(x.year, bin);
    if (h24) r.hour = decVal(x.hour, bin);
    else     r.hour = (decVal({1'b0, x.hour[6:0]}, bin) % 8'd12) + (x.hour[7] ? 8'd12 : 8'd0);
    return r;
  endfunction
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int UPD_CYCLES = 990
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [2:0] divCtl,
  input  logic       loadStb,
  input  logic       setHold,
  output strobe_t    strb,
  output logic       uip
);
  localparam int CW = $clog2(UPD_CYCLES + 1);

  logic          busy;
  logic [CW-1:0] winCnt;

  always_comb begin
    strb = '0;
    strb.advance = secTick && (divCtl == DIV_RUN) && !busy && !loadStb;
    strb.finish  = busy && (winCnt == CW'(UPD_CYCLES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      winCnt <= '0;
    end else if (strb.advance) begin
      busy   <= 1'b1;
      winCnt <= '0;
    end else if (strb.finish) begin
      busy   <= 1'b0;
    end else if (busy) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             uip <= 1'b0;
    else if (setHold)      uip <= 1'b0;
    else if (strb.advance) uip <= 1'b1;
    else if (strb.finish)  uip <= 1'b0;
  end

  // R3
  uip_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !setHold |=> uip);

  // R3
  uip_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !uip);

  // R7
  uip_set_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    setHold |=> !uip);
endmodule

// File: rtl/tod_dpath.sv
module tod_dpath
  import tod_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [2:0]  divCtl,
  input  logic        binMode,
  input  logic        hr24,
  input  logic        setHold,
  input  logic        alarmEn,
  input  logic        doneEn,
  input  logic        flagClr,
  input  logic        loadStb,
  input  tod_t        loadVal,
  input  logic [ALARM_FIELDS-1:0][DW-1:0] almVal,
  output tod_t        vis,
  output logic        irqFlag,
  output logic        alarmFlag,
  output logic        doneFlag
);
  tod_t cur;
  tod_t nextTod;
  tod_t nowFmt;
  logic prevSet;
  logic setFall;

  // carry chain for the one-second step
  logic c1, c2, c3, c4, c5;
  always_comb begin
    c1 = (cur.sec == 8'd59);
    c2 = c1 && (cur.min == 8'd59);
    c3 = c2 && (cur.hour == 8'd23);
    c4 = c3 && (cur.dom == monthDays(cur.mon, cur.year));
    c5 = c4 && (cur.mon == 8'd12);
    nextTod.sec  = c1 ? 8'd0 : cur.sec + 8'd1;
    nextTod.min  = c1 ? (c2 ? 8'd0 : cur.min + 8'd1) : cur.min;
    nextTod.hour = c2 ? (c3 ? 8'd0 : cur.hour + 8'd1) : cur.hour;
    nextTod.dow  = c3 ? ((cur.dow == 8'd7) ? 8'd1 : cur.dow + 8'd1) : cur.dow;
    nextTod.dom  = c3 ? (c4 ? 8'd1 : cur.dom + 8'd1) : cur.dom;
    nextTod.mon  = c4 ? (c5 ? 8'd1 : cur.mon + 8'd1) : cur.mon;
    nextTod.year = c5 ? ((cur.year == 8'd99) ? 8'd0 : cur.year + 8'd1) : cur.year;
  end

  assign setFall = prevSet && !setHold;
  assign nowFmt  = encTod(cur, binMode, hr24);

  always_ff @(posedge clk) begin
    if (!rstN) prevSet <= 1'b0;
    else       prevSet <= setHold;
  end

  // internal binary time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '{year: 8'd0, mon: 8'd1, dom: 8'd1, dow: 8'd1, hour: 8'd0, min: 8'd0, sec: 8'd0};
    end else if (loadStb && !setHold) begin
      cur <= decTod(loadVal, binMode, hr24);
    end else if (setFall) begin
      cur <= decTod(vis, binMode, hr24);
    end else if (strb.advance) begin
      cur <= nextTod;
    end
  end

  // host-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vis <= '{year: 8'h00, mon: 8'h01, dom: 8'h01, dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (loadStb) begin
      vis <= loadVal;
    end else if (strb.finish && !setHold) begin
      vis <= nowFmt;
    end
  end

  // alarm comparison, one lane per field
  logic [ALARM_FIELDS-1:0][DW-1:0] nowVal;
  logic [ALARM_FIELDS-1:0]         fieldHit;
  assign nowVal = {nowFmt.hour, nowFmt.min, nowFmt.sec};

  generate
    for (genvar i = 0; i < ALARM_FIELDS; i++) begin : g_alm
      assign fieldHit[i] = (almVal[i][DW-1:DW-2] == 2'b11) || (almVal[i] == nowVal[i]);
    end
  endgenerate

  logic setAlarm, setDone;
  assign setAlarm = strb.finish && alarmEn && (&fieldHit);
  assign setDone  = strb.finish && doneEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      doneFlag  <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      alarmFlag <= setAlarm | (alarmFlag & ~flagClr);
      doneFlag  <= setDone  | (doneFlag  & ~flagClr);
      irqFlag   <= setAlarm | setDone | (irqFlag & ~flagClr);
    end
  end

  // R2
  hold_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divCtl != DIV_RUN) && !loadStb && !setFall |=> $stable(cur));

  // R7
  vis_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    setHold && !loadStb |=> $stable(vis));

  // R9
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmFlag |-> irqFlag);

  // R10
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> irqFlag);
endmodule

// File: rtl/tod_engine.sv
module tod_engine
  import tod_pkg::*;
#(
  parameter int UPD_CYCLES = 990
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [2:0] divCtl,
  input  logic       binMode,
  input  logic       hr24,
  input  logic       setHold,
  input  logic       alarmEn,
  input  logic       doneEn,
  input  logic       flagClr,
  input  logic       loadStb,
  input  logic [7:0] loadSec,
  input  logic [7:0] loadMin,
  input  logic [7:0] loadHour,
  input  logic [7:0] loadDow,
  input  logic [7:0] loadDom,
  input  logic [7:0] loadMon,
  input  logic [7:0] loadYear,
  input  logic [7:0] alarmSec,
  input  logic [7:0] alarmMin,
  input  logic [7:0] alarmHour,
  output logic       uip,
  output logic [7:0] visSec,
  output logic [7:0] visMin,
  output logic [7:0] visHour,
  output logic [7:0] visDow,
  output logic [7:0] visDom,
  output logic [7:0] visMon,
  output logic [7:0] visYear,
  output logic       irqFlag,
  output logic       alarmFlag,
  output logic       doneFlag
);
  strobe_t strb;
  tod_t    loadVal;
  tod_t    vis;
  logic [ALARM_FIELDS-1:0][DW-1:0] almVal;

  assign loadVal = '{year: loadYear, mon: loadMon, dom: loadDom, dow: loadDow,
                     hour: loadHour, min: loadMin, sec: loadSec};
  assign almVal  = {alarmHour, alarmMin, alarmSec};

  tod_ctrl #(.UPD_CYCLES(UPD_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .divCtl  (divCtl),
    .loadStb (loadStb),
    .setHold (setHold),
    .strb    (strb),
    .uip     (uip)
  );

  tod_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .divCtl    (divCtl),
    .binMode   (binMode),
    .hr24      (hr24),
    .setHold   (setHold),
    .alarmEn   (alarmEn),
    .doneEn    (doneEn),
    .flagClr   (flagClr),
    .loadStb   (loadStb),
    .loadVal   (loadVal),
    .almVal    (almVal),
    .vis       (vis),
    .irqFlag   (irqFlag),
    .alarmFlag (alarmFlag),
    .doneFlag  (doneFlag)
  );

  assign visSec  = vis.sec;
  assign visMin  = vis.min;
  assign visHour = vis.hour;
  assign visDow  = vis.dow;
  assign visDom  = vis.dom;
  assign visMon  = vis.mon;
  assign visYear = vis.year;
endmodule

// File: tb/sim_tod_engine.sv
`timescale 1ns/1ps
module sim_tod_engine;
  localparam int UPD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [2:0] divCtl = 3'b010;
  logic bin = 1'b1, h24 = 1'b1;
  logic setHold = 1'b0, alarmEn = 1'b0, doneEn = 1'b0, flagClr = 1'b0, loadStb = 1'b0;
  logic [7:0] loadSec = 0, loadMin = 0, loadHour = 0, loadDow = 0, loadDom = 0, loadMon = 0, loadYear = 0;
  logic [7:0] alarmSec = 0, alarmMin = 0, alarmHour = 0;
  logic uip, irqFlag, alarmFlag, doneFlag;
  logic [7:0] visSec, visMin, visHour, visDow, visDom, visMon, visYear;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tod_engine #(.UPD_CYCLES(UPD)) u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .divCtl(divCtl), .binMode(bin), .hr24(h24),
    .setHold(setHold), .alarmEn(alarmEn), .doneEn(doneEn), .flagClr(flagClr), .loadStb(loadStb),
    .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour), .loadDow(loadDow),
    .loadDom(loadDom), .loadMon(loadMon), .loadYear(loadYear),
    .alarmSec(alarmSec), .alarmMin(alarmMin), .alarmHour(alarmHour),
    .uip(uip), .visSec(visSec), .visMin(visMin), .visHour(visHour), .visDow(visDow),
    .visDom(visDom), .visMon(visMon), .visYear(visYear),
    .irqFlag(irqFlag), .alarmFlag(alarmFlag), .doneFlag(doneFlag));

  function automatic logic [7:0] enc(int v);
    if (bin) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] encH(int h);
    if (h24) return enc(h);
    return enc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] pk(int s, int m, int h, int dw, int dm, int mo, int y);
    return {enc(y), enc(mo), enc(dm), enc(dw), encH(h), enc(m), enc(s)};
  endfunction

  function automatic logic [55:0] visNow();
    return {visYear, visMon, visDom, visDow, visHour, visMin, visSec};
  endfunction

  task automatic check(string req, logic [55:0] act, logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic ld(int s, int m, int h, int dw, int dm, int mo, int y);
    @(negedge clk);
    loadStb = 1'b1;
    loadSec = enc(s); loadMin = enc(m); loadHour = encH(h);
    loadDow = enc(dw); loadDom = enc(dm); loadMon = enc(mo); loadYear = enc(y);
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic doTick(string req, bit expUip);
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    check(req, 56'(uip), 56'(expUip));
    repeat (UPD - 1) @(negedge clk);
    check(req, 56'(uip), 56'(expUip));
    @(negedge clk);
    check(req, 56'(uip), 56'd0);
  endtask

  task automatic clr();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", visNow(), {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    check("R1", {53'd0, uip, alarmFlag, doneFlag}, 56'd0);
    check("R1", 56'(irqFlag), 56'd0);

    // R2 divider gating
    ld(0, 0, 0, 1, 1, 1, 0);
    doTick("R2", 1);
    check("R2", visNow(), pk(1, 0, 0, 1, 1, 1, 0));
    for (int d = 0; d < 8; d++) begin
      if (d == 2) continue;
      divCtl = 3'(d);
      doTick("R2", 0);
    end
    divCtl = 3'b010;
    doTick("R2", 1);
    check("R2", visNow(), pk(2, 0, 0, 1, 1, 1, 0));

    // R3 tick during an open window is ignored
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    check("R3", 56'(uip), 56'd1);
    repeat (UPD) @(negedge clk);
    check("R3", visNow(), pk(3, 0, 0, 1, 1, 1, 0));
    check("R3", 56'(uip), 56'd0);

    // R4 R5 hour sweep under all four formats
    for (int f = 0; f < 4; f++) begin
      bin = f[0]; h24 = f[1];
      for (int h = 0; h < 24; h++) begin
        ld(59, 59, h, 1, 1, 1, 0);
        doTick("R5", 1);
        if (h == 23) check("R5", visNow(), pk(0, 0, 0, 2, 2, 1, 0));
        else         check("R4", visNow(), pk(0, 0, h + 1, 1, 1, 1, 0));
      end
    end

    // R6 month-end sweep over several years
    bin = 1'b0; h24 = 1'b1;
    for (int yi = 0; yi < 4; yi++) begin
      int y;
      y = (yi == 0) ? 0 : (yi == 1) ? 3 : (yi == 2) ? 4 : 99;
      for (int m = 1; m <= 12; m++) begin
        ld(59, 59, 23, 7, mdays(m, y), m, y);
        doTick("R6", 1);
        check("R6", visNow(), pk(0, 0, 0, 1, 1, (m % 12) + 1,
                                 (m == 12) ? (y + 1) % 100 : y));
      end
    end
    ld(59, 59, 23, 3, 28, 2, 8);
    doTick("R6", 1);
    check("R6", visNow(), pk(0, 0, 0, 4, 29, 2, 8));

    // R7 SET freezes visible time while counting continues
    bin = 1'b1; h24 = 1'b1;
    ld(0, 0, 0, 1, 1, 1, 0);
    alarmEn = 1'b1; alarmSec = 8'd2; alarmMin = 8'd0; alarmHour = 8'd0;
    clr();
    @(negedge clk); setHold = 1'b1;
    doTick("R7", 0);
    check("R7", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'd0);
    doTick("R7", 0);
    check("R7", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'b110);
    check("R7", visNow(), pk(0, 0, 0, 1, 1, 1, 0));

    // R8 load under SET, then reload on SET falling
    alarmEn = 1'b0;
    ld(7, 6, 5, 2, 3, 4, 5);
    check("R8", visNow(), pk(7, 6, 5, 2, 3, 4, 5));
    doTick("R8", 0);
    check("R8", visNow(), pk(7, 6, 5, 2, 3, 4, 5));
    @(negedge clk); setHold = 1'b0;
    doTick("R8", 1);
    check("R8", visNow(), pk(8, 6, 5, 2, 3, 4, 5));

    // R9 alarm matching
    clr();
    // R11 flags cleared
    check("R11", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'd0);
    alarmEn = 1'b1;
    alarmSec = 8'hC0; alarmMin = 8'd20; alarmHour = 8'd10;
    ld(30, 20, 10, 1, 1, 1, 0);
    doTick("R9", 1);
    check("R9", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'b110);
    clr();
    alarmSec = 8'd31; alarmHour = 8'd11;
    ld(30, 20, 10, 1, 1, 1, 0);
    doTick("R9", 1);
    check("R9", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'd0);
    bin = 1'b0;
    alarmSec = 8'h45; alarmMin = 8'h59; alarmHour = 8'h13;
    ld(44, 59, 13, 1, 1, 1, 0);
    doTick("R9", 1);
    check("R9", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'b110);
    clr();
    alarmMin = 8'hC0; alarmHour = 8'hC0;
    ld(44, 1, 2, 1, 1, 1, 0);
    doTick("R9", 1);
    check("R9", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'b110);
    clr();
    alarmEn = 1'b0;
    ld(44, 1, 2, 1, 1, 1, 0);
    doTick("R9", 1);
    check("R9", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'd0);

    // R10 update-ended flag
    doneEn = 1'b1;
    doTick("R10", 1);
    check("R10", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'b101);
    clr();
    doneEn = 1'b0;
    doTick("R10", 1);
    check("R10", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'd0);

    // R11 set wins over clear in the same cycle
    doneEn = 1'b1;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    repeat (UPD - 1) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    check("R11", {53'd0, irqFlag, alarmFlag, doneFlag}, 56'b101);
    clr();
    doneEn = 1'b0;

    // R12 tick together with load is ignored
    bin = 1'b1;
    @(negedge clk);
    loadStb = 1'b1; secTick = 1'b1;
    loadSec = 8'd10; loadMin = 8'd11; loadHour = 8'd12;
    loadDow = 8'd3; loadDom = 8'd4; loadMon = 8'd5; loadYear = 8'd6;
    @(negedge clk);
    loadStb = 1'b0; secTick = 1'b0;
    check("R12", 56'(uip), 56'd0);
    repeat (UPD + 1) @(negedge clk);
    check("R12", visNow(), pk(10, 11, 12, 3, 4, 5, 6));
    doTick("R12", 1);
    check("R12", visNow(), pk(11, 11, 12, 3, 4, 5, 6));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule